// File: doc/BRIEF.md
# Tomlinson-Harashima Transmit Precoder

This block sits in a serial transmitter ahead of a DAC-style line driver. It pre-distorts a stream of PAM symbols so that the post-cursor intersymbol interference of a known channel cancels by the time the signal reaches the far end. Each outgoing sample is the mapped symbol minus a weighted sum of earlier outgoing samples. That weighted sum is a recursive, infinite-impulse-response feedback. A modulo fold then forces the result back into the amplitude window of the selected PAM order, so the recursion can never grow without bound.

The precoder accepts two symbols per clock, an earlier one on the even lane and a later one on the odd lane. This lets the feedback loop run at half the symbol rate. Most of the feedback sum is formed one clock ahead and held in registers. Only the newest two or three terms are added inside the critical cycle. Software-free control is limited to a PAM order select, a bypass select and a write port for the signed tap weights.

Top module: `thp_precoder`

## Requirements
- R1: Symbol mapping. In 4-PAM mode a two-bit code maps 00 to -3, 01 to -1, 11 to +1 and 10 to +3. In 2-PAM mode only bit 0 counts, with 0 giving -1 and 1 giving +1. One level step is 2^(DATA_W-3) output LSBs, which is 8 at the default width.
- R2: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and low one clock after a cycle with `in_valid` low. The samples of a pair appear on `out_even`/`out_odd` with that one-cycle latency.
- R3: With all tap weights zero, each output sample equals its mapped input symbol.
- R4: With `bypass` high for a pair, both output samples equal their mapped symbols whatever the tap weights are.
- R5: In normal operation, sample n equals wrap(d[n] - sum over k=1..TAPS of q(w_k, y[n-k])). Here d is the mapped symbol and y the earlier output samples. The even lane is sample n and the odd lane is sample n+1, and the history carries across pairs.
- R6: A tap term q(w, y) is (w*y + 2^(WGT_FRAC-1)) shifted arithmetically right by WGT_FRAC, saturated to the signed DATA_W range. Weights are two's complement with WGT_FRAC fraction bits, so 16 means 0.5 at default.
- R7: The modulo fold keeps the low DATA_W bits as a signed value in 4-PAM mode (range -32..31 at default). In 2-PAM mode it keeps the low DATA_W-1 bits, sign-extended (range -16..15).
- R8: A cycle with `in_valid` low leaves the feedback state untouched. The sample stream continues exactly as if that cycle were absent.
- R9: `tap_idx` value k-1 addresses the weight of the sample k positions back, so index 0 is the one-symbol delay. A write takes full effect for pairs presented from the second cycle after the write cycle on. `in_valid` must be low in the write cycle and in the cycle that follows it.
- R10: Reset clears all weights and the sample history to zero, drives `out_valid` low and sets both output samples to zero.
- R11: Samples emitted under bypass enter the history and feed back into later non-bypassed samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one symbol pair per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_4pam | input | 1 | 1 selects 4-PAM, 0 selects 2-PAM; sampled with each pair |
| bypass | input | 1 | 1 sends mapped symbols straight out; sampled with each pair |
| tap_we | input | 1 | Tap weight write strobe |
| tap_idx | input | $clog2(TAPS) | Tap select, 0 = one-symbol delay |
| tap_wdata | input | WGT_W | Signed weight to write |
| in_valid | input | 1 | A symbol pair is presented this cycle |
| in_sym_even | input | 2 | Earlier symbol code of the pair |
| in_sym_odd | input | 2 | Later symbol code of the pair |
| out_valid | output | 1 | Output pair valid |
| out_even | output | DATA_W | Precoded earlier sample, signed |
| out_odd | output | DATA_W | Precoded later sample, signed |

## Verification
The assertions assume the mode and bypass inputs presented alongside a pair describe that pair. They also assume the inputs carry known values outside reset, because the range and level-grid checks look back one cycle at those controls. The agreement between the pipelined sum and a sequential model holds only when tap writes fall in idle windows. The stimulus therefore pulls `in_valid` low for the write cycle and the cycle after it, and it changes the mode or bypass only together with a fresh pair.

// File: rtl/thp_pkg.sv
package thp_pkg;

   typedef enum logic {
      PAM_2 = 1'b0,
      PAM_4 = 1'b1
   } pam_order_e;

   // Gray-coded level for a two-bit symbol; 2-PAM uses bit 0 only.
   function automatic int pam_level(input logic [1:0] code, input pam_order_e order);
      int lvl;
      if (order == PAM_4) begin
         unique case (code)
            2'b00:   lvl = -3;
            2'b01:   lvl = -1;
            2'b11:   lvl = 1;
            default: lvl = 3;
         endcase
      end else begin
         lvl = code[0] ? 1 : -1;
      end
      return lvl;
   endfunction

endpackage

// File: rtl/thp_tap_mult.sv
// One feedback term: signed sample times signed weight, rounded to the
// sample grid and saturated to the sample width.
module thp_tap_mult #(
   parameter int DATA_W   = 6,
   parameter int WGT_W    = 6,
   parameter int WGT_FRAC = 5
) (
   input  logic [DATA_W-1:0] x,
   input  logic [WGT_W-1:0]  w,
   output logic [DATA_W-1:0] q
);
   localparam int PW   = DATA_W + WGT_W;
   localparam int RW   = PW + 1;
   localparam int MAXI = (1 << (DATA_W - 1)) - 1;
   localparam int MINI = -(1 << (DATA_W - 1));
   localparam int HALF = 1 << (WGT_FRAC - 1);

   logic signed [PW-1:0] prod;
   logic signed [RW-1:0] rnd;
   logic signed [RW-1:0] shf;

   always_comb begin
      prod = PW'($signed(x)) * PW'($signed(w));
      rnd  = RW'(prod) + RW'(HALF);
      shf  = rnd >>> WGT_FRAC;
      if (int'(shf) > MAXI)      q = DATA_W'(MAXI);
      else if (int'(shf) < MINI) q = DATA_W'(MINI);
      else                       q = shf[DATA_W-1:0];
   end
endmodule

// File: rtl/thp_tap_bank.sv
// Writable signed weight registers, index 0 = one-symbol delay.
module thp_tap_bank #(
   parameter int TAPS  = 8,
   parameter int WGT_W = 6,
   localparam int IDX_W = $clog2(TAPS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [IDX_W-1:0]            idx,
   input  logic [WGT_W-1:0]            wdata,
   output logic [TAPS-1:0][WGT_W-1:0]  taps_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taps_o <= '0;
      end else if (we && (32'(idx) < TAPS)) begin
         taps_o[idx] <= wdata;
      end
   end

   // R9: weights change only through the write strobe
   a_r9_tap_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(taps_o));
endmodule

// File: rtl/thp_presum.sv
// Forms the older part of the feedback sum one cycle ahead.  When the
// current cycle accepts a pair the history is about to shift by two, so
// operands are taken two positions nearer; otherwise from the same spot.
module thp_presum #(
   parameter int TAPS     = 8,
   parameter int DATA_W   = 6,
   parameter int WGT_W    = 6,
   parameter int WGT_FRAC = 5,
   parameter int SUM_W    = 10
) (
   input  logic                         advance,
   input  logic [TAPS-1:0][DATA_W-1:0]  hist,
   input  logic [TAPS-1:2][WGT_W-1:0]   taps,
   output logic signed [SUM_W-1:0]      even_sum,
   output logic signed [SUM_W-1:0]      odd_sum
);
   logic [TAPS-1:2][DATA_W-1:0] q_even;
   logic [TAPS-1:3][DATA_W-1:0] q_odd;

   for (genvar t = 2; t < TAPS; t++) begin : g_even
      logic [DATA_W-1:0] xe;
      assign xe = advance ? hist[t-2] : hist[t];
      thp_tap_mult #(.DATA_W(DATA_W), .WGT_W(WGT_W), .WGT_FRAC(WGT_FRAC)) u_mul (
         .x(xe), .w(taps[t]), .q(q_even[t]));
   end

   for (genvar t = 3; t < TAPS; t++) begin : g_odd
      logic [DATA_W-1:0] xo;
      assign xo = advance ? hist[t-3] : hist[t-1];
      thp_tap_mult #(.DATA_W(DATA_W), .WGT_W(WGT_W), .WGT_FRAC(WGT_FRAC)) u_mul (
         .x(xo), .w(taps[t]), .q(q_odd[t]));
   end

   always_comb begin
      even_sum = '0;
      for (int t = 2; t < TAPS; t++) even_sum += SUM_W'($signed(q_even[t]));
      odd_sum = '0;
      for (int t = 3; t < TAPS; t++) odd_sum += SUM_W'($signed(q_odd[t]));
   end
endmodule

// File: rtl/thp_lane.sv
// One output lane: maps the symbol, adds the newest feedback terms to the
// precomputed sum, subtracts and folds into the PAM window.
module thp_lane #(
   parameter int DATA_W   = 6,
   parameter int WGT_W    = 6,
   parameter int WGT_FRAC = 5,
   parameter int SUM_W    = 10,
   parameter int NDIR     = 2
) (
   input  logic [1:0]                   code,
   input  logic                         pam4,
   input  logic                         byp,
   input  logic signed [SUM_W-1:0]      presum,
   input  logic [NDIR-1:0][DATA_W-1:0]  xs,
   input  logic [NDIR-1:0][WGT_W-1:0]   ws,
   output logic [DATA_W-1:0]            y
);
   import thp_pkg::*;

   localparam int UNIT = 1 << (DATA_W - 3);

   logic signed [DATA_W-1:0]  dsym;
   logic [NDIR-1:0][DATA_W-1:0] q_dir;
   logic signed [SUM_W-1:0]   acc;
   logic [DATA_W-1:0]         low;
   logic [DATA_W-1:0]         folded;

   always_comb dsym = DATA_W'(pam_level(code, pam_order_e'(pam4)) * UNIT);

   for (genvar j = 0; j < NDIR; j++) begin : g_dir
      thp_tap_mult #(.DATA_W(DATA_W), .WGT_W(WGT_W), .WGT_FRAC(WGT_FRAC)) u_mul (
         .x(xs[j]), .w(ws[j]), .q(q_dir[j]));
   end

   always_comb begin
      acc = presum;
      for (int j = 0; j < NDIR; j++) acc += SUM_W'($signed(q_dir[j]));
      low    = DATA_W'(SUM_W'(dsym) - acc);
      folded = pam4 ? low : {low[DATA_W-2], low[DATA_W-2:0]};
      y      = byp ? dsym : folded;
   end
endmodule

// File: rtl/thp_precoder.sv
module thp_precoder #(
   parameter int TAPS     = 8,
   parameter int DATA_W   = 6,
   parameter int WGT_W    = 6,
   parameter int WGT_FRAC = 5,
   localparam int IDX_W   = $clog2(TAPS),
   localparam int SUM_W   = DATA_W + $clog2(TAPS) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_4pam,
   input  logic              bypass,
   input  logic              tap_we,
   input  logic [IDX_W-1:0]  tap_idx,
   input  logic [WGT_W-1:0]  tap_wdata,
   input  logic              in_valid,
   input  logic [1:0]        in_sym_even,
   input  logic [1:0]        in_sym_odd,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_even,
   output logic [DATA_W-1:0] out_odd
);
   // elaboration-time parameter checks
   if (TAPS < 4) begin : g_bad_taps
      $error("thp_precoder: TAPS must be at least 4");
   end
   if (DATA_W < 4) begin : g_bad_width
      $error("thp_precoder: DATA_W must be at least 4");
   end
   if (WGT_FRAC < 1 || WGT_FRAC >= WGT_W + DATA_W) begin : g_bad_frac
      $error("thp_precoder: WGT_FRAC out of range");
   end

   logic [TAPS-1:0][WGT_W-1:0]  tap_w;
   logic [TAPS-1:0][DATA_W-1:0] hist;       // index 0 = newest sample
   logic signed [SUM_W-1:0]     pre_even_d, pre_odd_d;
   logic signed [SUM_W-1:0]     pre_even_q, pre_odd_q;
   logic [DATA_W-1:0]           y_even, y_odd;
   logic [1:0][DATA_W-1:0]      xs_even, ws_even_x;
   logic [1:0][WGT_W-1:0]       ws_even;
   logic [2:0][DATA_W-1:0]      xs_odd;
   logic [2:0][WGT_W-1:0]       ws_odd;

   thp_tap_bank #(.TAPS(TAPS), .WGT_W(WGT_W)) u_taps (
      .clk(clk), .rst_n(rst_n), .we(tap_we), .idx(tap_idx),
      .wdata(tap_wdata), .taps_o(tap_w));

   thp_presum #(.TAPS(TAPS), .DATA_W(DATA_W), .WGT_W(WGT_W),
                .WGT_FRAC(WGT_FRAC), .SUM_W(SUM_W)) u_presum (
      .advance(in_valid), .hist(hist), .taps(tap_w[TAPS-1:2]),
      .even_sum(pre_even_d), .odd_sum(pre_odd_d));

   // even lane: newest two history samples
   assign xs_even   = {hist[1], hist[0]};
   assign ws_even   = {tap_w[1], tap_w[0]};
   assign ws_even_x = '0;

   // odd lane: the even sample of this pair plus two history samples
   assign xs_odd = {hist[1], hist[0], y_even};
   assign ws_odd = {tap_w[2], tap_w[1], tap_w[0]};

   thp_lane #(.DATA_W(DATA_W), .WGT_W(WGT_W), .WGT_FRAC(WGT_FRAC),
              .SUM_W(SUM_W), .NDIR(2)) u_even (
      .code(in_sym_even), .pam4(mode_4pam), .byp(bypass), .presum(pre_even_q),
      .xs(xs_even), .ws(ws_even), .y(y_even));

   thp_lane #(.DATA_W(DATA_W), .WGT_W(WGT_W), .WGT_FRAC(WGT_FRAC),
              .SUM_W(SUM_W), .NDIR(3)) u_odd (
      .code(in_sym_odd), .pam4(mode_4pam), .byp(bypass), .presum(pre_odd_q),
      .xs(xs_odd), .ws(ws_odd), .y(y_odd));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist       <= '0;
         pre_even_q <= '0;
         pre_odd_q  <= '0;
         out_valid  <= 1'b0;
         out_even   <= '0;
         out_odd    <= '0;
      end else begin
         pre_even_q <= pre_even_d;
         pre_odd_q  <= pre_odd_d;
         out_valid  <= in_valid;
         if (in_valid) begin
            hist     <= {hist[TAPS-3:0], y_even, y_odd};
            out_even <= y_even;
            out_odd  <= y_odd;
         end
      end
   end

   // R2: valid follows the input by one cycle
   a_r2_valid_follow : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r2_idle_low : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R8: idle cycles leave the feedback history alone
   a_r8_hist_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(hist));
   // R7: 2-PAM samples stay inside the narrower window
   a_r7_pam2_range : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(mode_4pam)) |->
         (out_even[DATA_W-1] == out_even[DATA_W-2]) &&
         (out_odd[DATA_W-1] == out_odd[DATA_W-2]));
   // R4: bypassed samples sit on odd multiples of one level step
   a_r4_bypass_grid : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(bypass)) |->
         (out_even[DATA_W-3:0] == {1'b1, {(DATA_W-3){1'b0}}}) &&
         (out_odd[DATA_W-3:0] == {1'b1, {(DATA_W-3){1'b0}}}));
   // R10: first cycle out of reset is quiet
   a_r10_reset_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid);

endmodule

// File: tb/thp_precoder_tb_top.sv
`timescale 1ns/1ps
module thp_precoder_tb_top;
   localparam int TAPS = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_4pam = 1'b1;
   logic       bypass = 1'b0;
   logic       tap_we = 1'b0;
   logic [2:0] tap_idx = '0;
   logic [5:0] tap_wdata = '0;
   logic       in_valid = 1'b0;
   logic [1:0] in_sym_even = '0;
   logic [1:0] in_sym_odd = '0;
   logic       out_valid;
   logic [5:0] out_even, out_odd;

   int checks = 0;
   int fails = 0;
   int mh[TAPS];
   int mw[TAPS];

   always #2.5 clk = ~clk;

   thp_precoder dut_i (
      .clk(clk), .rst_n(rst_n), .mode_4pam(mode_4pam), .bypass(bypass),
      .tap_we(tap_we), .tap_idx(tap_idx), .tap_wdata(tap_wdata),
      .in_valid(in_valid), .in_sym_even(in_sym_even), .in_sym_odd(in_sym_odd),
      .out_valid(out_valid), .out_even(out_even), .out_odd(out_odd));

   // ---------------- reference model ----------------
   function automatic int m_map(int code, bit m4);
      int lvl;
      if (m4) begin
         case (code & 3)
            0: lvl = -3;
            1: lvl = -1;
            3: lvl = 1;
            default: lvl = 3;
         endcase
      end else begin
         lvl = (code & 1) ? 1 : -1;
      end
      return lvl * 8;
   endfunction

   function automatic int m_term(int w, int x);
      int r;
      r = (w * x + 16) >>> 5;
      if (r > 31) r = 31;
      if (r < -32) r = -32;
      return r;
   endfunction

   function automatic int m_fold(int v, bit m4);
      int r;
      if (m4) begin
         r = v & 63;
         if (r >= 32) r -= 64;
      end else begin
         r = v & 31;
         if (r >= 16) r -= 32;
      end
      return r;
   endfunction

   task automatic m_step(int code, bit m4, bit byp, output int y);
      int d, s;
      d = m_map(code, m4);
      s = 0;
      for (int k = 0; k < TAPS; k++) s += m_term(mw[k], mh[k]);
      y = byp ? d : m_fold(d - s, m4);
      for (int k = TAPS - 1; k > 0; k--) mh[k] = mh[k-1];
      mh[0] = y;
   endtask

   // ---------------- helpers ----------------
   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_pair(int ce, int co, bit m4, bit byp, string req);
      int ee, eo;
      in_valid    = 1'b1;
      in_sym_even = ce[1:0];
      in_sym_odd  = co[1:0];
      mode_4pam   = m4;
      bypass      = byp;
      m_step(ce, m4, byp, ee);
      m_step(co, m4, byp, eo);
      @(negedge clk);
      check({req, " valid"}, int'(out_valid), 1);
      check({req, " even"}, int'($signed(out_even)), ee);
      check({req, " odd"}, int'($signed(out_odd)), eo);
   endtask

   task automatic idle(string req);
      in_valid = 1'b0;
      @(negedge clk);
      check({req, " idle valid"}, int'(out_valid), 0);
   endtask

   // R9: write, then keep in_valid low for the write cycle and the next
   task automatic write_tap(int idx, int w);
      in_valid  = 1'b0;
      tap_we    = 1'b1;
      tap_idx   = idx[2:0];
      tap_wdata = w[5:0];
      mw[idx]   = w;
      @(negedge clk);
      tap_we = 1'b0;
      @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      bit m4;
      void'($urandom(32'd4242));
      for (int k = 0; k < TAPS; k++) begin
         mh[k] = 0;
         mw[k] = 0;
      end
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 out_valid", int'(out_valid), 0);
      check("R10 out_even", int'($signed(out_even)), 0);
      check("R10 out_odd", int'($signed(out_odd)), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 after release", int'(out_valid), 0);

      // R1 / R3: weights are zero after reset, output is the mapped symbol
      do_pair(0, 1, 1'b1, 1'b0, "R1 R3 4pam");
      check("R1 code00", int'($signed(out_even)), -24);
      check("R1 code01", int'($signed(out_odd)), -8);
      do_pair(3, 2, 1'b1, 1'b0, "R1 R3 4pam");
      check("R1 code11", int'($signed(out_even)), 8);
      check("R1 code10", int'($signed(out_odd)), 24);
      do_pair(2, 3, 1'b0, 1'b0, "R1 R3 2pam");
      check("R1 2pam bit0=0", int'($signed(out_even)), -8);
      check("R1 2pam bit0=1", int'($signed(out_odd)), 8);
      idle("R2");

      // R9: single tap at index 0 (one-symbol delay)
      write_tap(0, 16);
      do_pair(2, 2, 1'b1, 1'b0, "R9 tap0");
      do_pair(0, 3, 1'b1, 1'b0, "R9 tap0");
      write_tap(0, 0);
      write_tap(TAPS - 1, -20);
      for (int i = 0; i < 6; i++) do_pair(i & 3, (i + 1) & 3, 1'b1, 1'b0, "R9 last tap");

      // R5 / R8: random weights, symbols, mode segments and idle gaps
      m4 = 1'b1;
      for (int i = 0; i < 360; i++) begin
         if (i % 90 == 0) begin
            for (int k = 0; k < TAPS; k++) write_tap(k, int'($urandom_range(63)) - 32);
         end
         if (i % 45 == 0) m4 = 1'($urandom_range(1));
         if ($urandom_range(4) == 0) idle("R8");
         do_pair(int'($urandom_range(3)), int'($urandom_range(3)), m4, 1'b0,
                 m4 ? "R5 4pam" : "R7 2pam");
      end

      // R4 / R11: bypass with nonzero weights, then resume
      for (int i = 0; i < 4; i++)
         do_pair(i & 3, 3 - (i & 3), 1'b1, 1'b1, "R4 bypass");
      for (int i = 0; i < 6; i++)
         do_pair((i * 3) & 3, i & 3, 1'b1, 1'b0, "R11 after bypass");

      // R6: extreme weights to drive rounding and saturation
      for (int k = 0; k < TAPS; k++) write_tap(k, -32);
      for (int i = 0; i < 20; i++)
         do_pair(int'($urandom_range(3)), int'($urandom_range(3)), 1'b1, 1'b0, "R6 neg");
      for (int k = 0; k < TAPS; k++) write_tap(k, 31);
      for (int i = 0; i < 20; i++)
         do_pair(int'($urandom_range(3)), int'($urandom_range(3)), 1'($urandom_range(1)),
                 1'b0, "R6 pos");

      // R3 again: zero weights restore plain mapping after heavy history
      for (int k = 0; k < TAPS; k++) write_tap(k, 0);
      do_pair(0, 2, 1'b1, 1'b0, "R3 zero taps");
      check("R3 even level", int'($signed(out_even)), -24);
      check("R3 odd level", int'($signed(out_odd)), 24);
      idle("R2");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule